// File: doc/BRIEF.md
# Branch Trace Message Encoder

This block sits beside a processor core and watches the stream of retired instructions, one record per cycle. Each record gives an instruction class code, the instruction address, the instruction size in halfwords and a cycle timestamp. From this stream the block rebuilds program flow and decides when a trace message is due. A due message leaves as a set of fields (message code, instruction count, address field, branch type, event field and timestamp) on a valid/ready interface. A downstream serializer turns those fields into bytes.

The decision always looks one record back. A branch message is raised when the record after a taken conditional branch or an uninferable jump arrives, so the new target address is known at that point. The instruction count, the target address and the timestamp are sent as compact values. The count runs since the last message, in halfwords. Addresses and timestamps go out as the XOR of the new value with the last value sent. A three-state controller (idle, data, full) handles trace start, counter saturation and trace stop. When the serializer stalls, the block holds its message and pulls its own ready toward the core low.

Top module: `brtrace_encoder`

## Requirements
- R1: After synchronous reset the block has no message pending (msg_valid low), accepts records (rec_ready high) and is in the idle state.
- R2: In the idle state with trace enabled, the next accepted record produces a sync message. It has code 9, count 0, event field 5, address field equal to the record address shifted right by one, and the record's full timestamp. Branch type is 0. The block then enters the data state, with the count set to that record's size.
- R3: In the data state the count grows by each record's size field, which is 1 or 2 halfwords. Records whose previous record was neither class 5 nor class 10 produce no message.
- R4: When the previous record had class 5 (taken conditional branch), the current record produces a message with code 3. Its count is the count held before the current record. The count then restarts at the current record's size.
- R5: When the previous record had class 10 (uninferable jump), the current record produces a message with code 4 and branch type 0. Its count follows the same rule as R4. Its address field is (current address >> 1) XOR the last address sent, and that value of current address >> 1 becomes the last address sent.
- R6: Messages with code 3, 4 or 33 carry the previous record's timestamp XOR the last timestamp sent. The previous record's timestamp then becomes the last timestamp sent. Sync messages also set the last timestamp and last address.
- R7: When the count after a record reaches 2^FULL_LOG2 or more, the block enters the full state. The next enabled record then produces a message with code 27, carrying the saturated count and zero address and timestamp fields. The count is cleared and does not include that record, and the block returns to the data state.
- R8: A record accepted in the data state while trace is disabled produces a message with code 33, event field 4 and the held count. The block then enters the idle state with the count cleared. Records accepted while disabled in the idle or full state produce no message.
- R9: A rising edge of the enable input forces the idle state, also from the full state, so the next enabled record produces a sync message as in R2.
- R10: While a message is pending and msg_ready is low, rec_ready is low and all message outputs hold their values. A message leaves on a cycle where msg_valid and msg_ready are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Trace enable |
| rec_valid | input | 1 | Retired-instruction record present |
| rec_ready | output | 1 | Block can take a record this cycle |
| rec_type | input | 4 | Instruction class code (5 taken branch, 10 uninferable jump) |
| rec_addr | input | ADDR_W | Instruction address |
| rec_hsize | input | 2 | Instruction size in halfwords (1 or 2) |
| rec_tstamp | input | TS_W | Cycle timestamp of the record |
| msg_valid | output | 1 | Message pending |
| msg_ready | input | 1 | Serializer takes the message |
| msg_code | output | 6 | Message code (9, 3, 4, 27, 33) |
| msg_icnt | output | FULL_LOG2+1 | Instruction count in halfwords |
| msg_addr | output | ADDR_W | Full or XOR-compressed address field |
| msg_btype | output | 2 | Branch type |
| msg_event | output | 4 | Sync reason or event code |
| msg_tstamp | output | TS_W | Full or XOR-compressed timestamp |

## Verification
The bench builds the block with FULL_LOG2 set to 4, so saturation is reached after about eight two-halfword records instead of sixteen thousand. This puts both entries into the full state, and the exit from it by a fresh enable edge, inside a short directed run. Addresses are 32 bits and timestamps 16 bits, which keeps the hand-computed XOR values readable. Nothing in the compression or the control path depends on these widths.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_FULL = 2'd2
    } brt_state_e;

    localparam logic [3:0] TY_BR_TAKEN  = 4'd5;
    localparam logic [3:0] TY_JMP_UNINF = 4'd10;

    localparam logic [5:0] MC_DBR  = 6'd3;
    localparam logic [5:0] MC_IBR  = 6'd4;
    localparam logic [5:0] MC_SYNC = 6'd9;
    localparam logic [5:0] MC_FULL = 6'd27;
    localparam logic [5:0] MC_CORR = 6'd33;

    localparam logic [3:0] EV_TRACE_ON = 4'd5;
    localparam logic [3:0] EV_DISABLE  = 4'd4;
    localparam logic [1:0] BT_INDIRECT = 2'd0;

    typedef struct packed {
        logic [5:0] code;
        logic [1:0] btype;
        logic [3:0] ev;
    } brt_hdr_t;

    localparam int HDR_W = 12;

    function automatic brt_hdr_t mk_hdr(logic [5:0] c, logic [1:0] b, logic [3:0] e);
        brt_hdr_t h;
        h.code  = c;
        h.btype = b;
        h.ev    = e;
        return h;
    endfunction

endpackage

// File: rtl/brt_history.sv
module brt_history
    import brt_pkg::*;
#(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic [3:0]      cur_type,
    input  logic [TS_W-1:0] cur_ts,
    output logic [3:0]      prev_type,
    output logic [TS_W-1:0] prev_ts
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_type <= 4'd0;
            prev_ts   <= '0;
        end else if (take) begin
            prev_type <= cur_type;
            prev_ts   <= cur_ts;
        end
    end

    // R4
    hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> prev_type == $past(cur_type));

endmodule

// File: rtl/brt_decide.sv
module brt_decide
    import brt_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int TS_W      = 64,
    parameter int FULL_LOG2 = 15,
    localparam int CNT_W    = FULL_LOG2 + 1
) (
    input  brt_state_e        st,
    input  logic              en,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [1:0]        cur_hsize,
    input  logic [TS_W-1:0]   cur_ts,
    input  logic [3:0]        prev_type,
    input  logic [TS_W-1:0]   prev_ts,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [TS_W-1:0]   last_ts,
    output logic              gen,
    output brt_hdr_t          hdr,
    output logic [CNT_W-1:0]  m_icnt,
    output logic [ADDR_W-1:0] m_addr,
    output logic [TS_W-1:0]   m_ts,
    output brt_state_e        nxt_state,
    output logic [CNT_W-1:0]  nxt_cnt,
    output logic              upd_addr,
    output logic [ADDR_W-1:0] new_addr,
    output logic              upd_ts,
    output logic [TS_W-1:0]   new_ts
);

    localparam logic [CNT_W-1:0] LIMIT = {1'b1, {FULL_LOG2{1'b0}}};

    logic [CNT_W-1:0]  hs;
    logic [CNT_W-1:0]  sum;
    logic [ADDR_W-1:0] half_addr;
    logic [TS_W-1:0]   ts_delta;

    assign hs        = {{(CNT_W-2){1'b0}}, cur_hsize};
    assign sum       = cnt + hs;
    assign half_addr = cur_addr >> 1;
    assign ts_delta  = prev_ts ^ last_ts;

    always_comb begin
        gen       = 1'b0;
        hdr       = mk_hdr(6'd0, 2'd0, 4'd0);
        m_icnt    = '0;
        m_addr    = '0;
        m_ts      = '0;
        nxt_state = st;
        nxt_cnt   = cnt;
        upd_addr  = 1'b0;
        new_addr  = half_addr;
        upd_ts    = 1'b0;
        new_ts    = prev_ts;
        unique case (st)
            ST_IDLE: begin
                if (en) begin
                    gen       = 1'b1;
                    hdr       = mk_hdr(MC_SYNC, 2'd0, EV_TRACE_ON);
                    m_addr    = half_addr;
                    m_ts      = cur_ts;
                    upd_addr  = 1'b1;
                    upd_ts    = 1'b1;
                    new_ts    = cur_ts;
                    nxt_state = ST_DATA;
                    nxt_cnt   = hs;
                end
            end
            ST_DATA: begin
                if (!en) begin
                    gen       = 1'b1;
                    hdr       = mk_hdr(MC_CORR, 2'd0, EV_DISABLE);
                    m_icnt    = cnt;
                    m_ts      = ts_delta;
                    upd_ts    = 1'b1;
                    nxt_state = ST_IDLE;
                    nxt_cnt   = '0;
                end else begin
                    if (prev_type == TY_BR_TAKEN) begin
                        gen     = 1'b1;
                        hdr     = mk_hdr(MC_DBR, 2'd0, 4'd0);
                        m_icnt  = cnt;
                        m_ts    = ts_delta;
                        upd_ts  = 1'b1;
                        nxt_cnt = hs;
                    end else if (prev_type == TY_JMP_UNINF) begin
                        gen      = 1'b1;
                        hdr      = mk_hdr(MC_IBR, BT_INDIRECT, 4'd0);
                        m_icnt   = cnt;
                        m_addr   = half_addr ^ last_addr;
                        m_ts     = ts_delta;
                        upd_addr = 1'b1;
                        upd_ts   = 1'b1;
                        nxt_cnt  = hs;
                    end else begin
                        nxt_cnt = sum;
                    end
                    nxt_state = (nxt_cnt >= LIMIT) ? ST_FULL : ST_DATA;
                end
            end
            ST_FULL: begin
                if (en) begin
                    gen       = 1'b1;
                    hdr       = mk_hdr(MC_FULL, 2'd0, 4'd0);
                    m_icnt    = cnt;
                    nxt_state = ST_DATA;
                    nxt_cnt   = '0;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/brt_msg_reg.sv
module brt_msg_reg #(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [PW-1:0] pay_in,
    input  logic          ready,
    output logic          valid,
    output logic [PW-1:0] pay_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            pay_out <= '0;
        end else if (load) begin
            valid   <= 1'b1;
            pay_out <= pay_in;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(pay_out));

endmodule

// File: rtl/brtrace_encoder.sv
module brtrace_encoder
    import brt_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int TS_W      = 64,
    parameter int FULL_LOG2 = 15,
    localparam int CNT_W    = FULL_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trace_en,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [3:0]        rec_type,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic [1:0]        rec_hsize,
    input  logic [TS_W-1:0]   rec_tstamp,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [5:0]        msg_code,
    output logic [CNT_W-1:0]  msg_icnt,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [1:0]        msg_btype,
    output logic [3:0]        msg_event,
    output logic [TS_W-1:0]   msg_tstamp
);

    localparam int PW = HDR_W + CNT_W + ADDR_W + TS_W;
    localparam logic [CNT_W-1:0] LIMIT = {1'b1, {FULL_LOG2{1'b0}}};

    brt_state_e        state_q;
    brt_state_e        eff_state;
    brt_state_e        nxt_state;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  nxt_cnt;
    logic [ADDR_W-1:0] last_addr_q;
    logic [ADDR_W-1:0] new_addr;
    logic [TS_W-1:0]   last_ts_q;
    logic [TS_W-1:0]   new_ts;
    logic              en_q;
    logic              en_rise;
    logic              acc;
    logic              gen;
    logic              upd_addr;
    logic              upd_ts;
    logic [3:0]        prev_type;
    logic [TS_W-1:0]   prev_ts;
    brt_hdr_t          hdr;
    brt_hdr_t          hdr_out;
    logic [CNT_W-1:0]  m_icnt;
    logic [ADDR_W-1:0] m_addr;
    logic [TS_W-1:0]   m_ts;
    logic [PW-1:0]     pay_in;
    logic [PW-1:0]     pay_out;

    assign rec_ready = !msg_valid || msg_ready;
    assign acc       = rec_valid && rec_ready;
    assign en_rise   = trace_en && !en_q;
    assign eff_state = en_rise ? ST_IDLE : state_q;

    brt_history #(.TS_W(TS_W)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .take      (acc),
        .cur_type  (rec_type),
        .cur_ts    (rec_tstamp),
        .prev_type (prev_type),
        .prev_ts   (prev_ts)
    );

    brt_decide #(.ADDR_W(ADDR_W), .TS_W(TS_W), .FULL_LOG2(FULL_LOG2)) u_dec (
        .st        (eff_state),
        .en        (trace_en),
        .cur_addr  (rec_addr),
        .cur_hsize (rec_hsize),
        .cur_ts    (rec_tstamp),
        .prev_type (prev_type),
        .prev_ts   (prev_ts),
        .cnt       (cnt_q),
        .last_addr (last_addr_q),
        .last_ts   (last_ts_q),
        .gen       (gen),
        .hdr       (hdr),
        .m_icnt    (m_icnt),
        .m_addr    (m_addr),
        .m_ts      (m_ts),
        .nxt_state (nxt_state),
        .nxt_cnt   (nxt_cnt),
        .upd_addr  (upd_addr),
        .new_addr  (new_addr),
        .upd_ts    (upd_ts),
        .new_ts    (new_ts)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            last_addr_q <= '0;
            last_ts_q   <= '0;
            en_q        <= 1'b0;
        end else begin
            en_q <= trace_en;
            if (acc) begin
                state_q <= nxt_state;
                cnt_q   <= nxt_cnt;
                if (upd_addr) last_addr_q <= new_addr;
                if (upd_ts)   last_ts_q   <= new_ts;
            end else if (en_rise) begin
                state_q <= ST_IDLE;
            end
        end
    end

    assign pay_in = {hdr, m_icnt, m_addr, m_ts};

    brt_msg_reg #(.PW(PW)) u_msg (
        .clk     (clk),
        .rst     (rst),
        .load    (acc && gen),
        .pay_in  (pay_in),
        .ready   (msg_ready),
        .valid   (msg_valid),
        .pay_out (pay_out)
    );

    assign hdr_out    = pay_out[PW-1 -: HDR_W];
    assign msg_code   = hdr_out.code;
    assign msg_btype  = hdr_out.btype;
    assign msg_event  = hdr_out.ev;
    assign msg_icnt   = pay_out[ADDR_W+TS_W +: CNT_W];
    assign msg_addr   = pay_out[TS_W +: ADDR_W];
    assign msg_tstamp = pay_out[TS_W-1:0];

    // R10
    core_stall_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |-> !rec_ready);

    // R7
    full_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_FULL |-> cnt_q >= LIMIT);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT + 1'b1);

    // R2
    sync_zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_code == MC_SYNC |-> msg_icnt == '0 && msg_event == EV_TRACE_ON);

    // R8
    corr_event_chk: assert property (@(posedge clk) disable iff (rst)
        acc && state_q == ST_DATA && !trace_en && !en_rise |=> msg_valid && msg_code == MC_CORR);

endmodule

// File: tb/brtrace_encoder_test.sv
module brtrace_encoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int TS_W       = 16;
    localparam int FULL_LOG2  = 4;
    localparam int CNT_W      = FULL_LOG2 + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              trace_en = 1'b0;
    logic              rec_valid = 1'b0;
    logic              rec_ready;
    logic [3:0]        rec_type = 4'd0;
    logic [ADDR_W-1:0] rec_addr = '0;
    logic [1:0]        rec_hsize = 2'd2;
    logic [TS_W-1:0]   rec_tstamp = '0;
    logic              msg_valid;
    logic              msg_ready = 1'b1;
    logic [5:0]        msg_code;
    logic [CNT_W-1:0]  msg_icnt;
    logic [ADDR_W-1:0] msg_addr;
    logic [1:0]        msg_btype;
    logic [3:0]        msg_event;
    logic [TS_W-1:0]   msg_tstamp;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brtrace_encoder #(.ADDR_W(ADDR_W), .TS_W(TS_W), .FULL_LOG2(FULL_LOG2)) uut (
        .clk(clk), .rst(rst), .trace_en(trace_en),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_type(rec_type),
        .rec_addr(rec_addr), .rec_hsize(rec_hsize), .rec_tstamp(rec_tstamp),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_code(msg_code),
        .msg_icnt(msg_icnt), .msg_addr(msg_addr), .msg_btype(msg_btype),
        .msg_event(msg_event), .msg_tstamp(msg_tstamp)
    );

    task automatic check(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(logic [3:0] t, logic [ADDR_W-1:0] a, logic [1:0] h, logic [TS_W-1:0] ts);
        @(negedge clk);
        rec_type = t; rec_addr = a; rec_hsize = h; rec_tstamp = ts; rec_valid = 1'b1;
        @(posedge clk);
        #1;
        rec_valid = 1'b0;
    endtask

    task automatic expect_msg(string req, logic [5:0] c, longint ic, longint ad,
                              logic [1:0] bt, logic [3:0] ev, longint ts);
        check(req, "valid", msg_valid, 1);
        check(req, "code", msg_code, c);
        check(req, "icnt", msg_icnt, ic);
        check(req, "addr", msg_addr, ad);
        check(req, "btype", msg_btype, bt);
        check(req, "event", msg_event, ev);
        check(req, "tstamp", msg_tstamp, ts);
    endtask

    task automatic expect_none(string req);
        check(req, "no message", msg_valid, 0);
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle_cycles(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "msg_valid after reset", msg_valid, 0);
        check("R1", "rec_ready after reset", rec_ready, 1);
    endtask

    task automatic t_sync;
        trace_en = 1'b1;
        idle_cycles(1);
        push(4'd0, 32'h1000, 2'd2, 16'd100);
        expect_msg("R2", 6'd9, 0, 32'h800, 2'd0, 4'd5, 100);
    endtask

    task automatic t_direct;
        push(4'd0, 32'h1004, 2'd2, 16'd101);
        expect_none("R3");
        push(4'd5, 32'h1008, 2'd1, 16'd102);
        expect_none("R3");
        push(4'd0, 32'h2000, 2'd2, 16'd103);
        expect_msg("R4", 6'd3, 5, 0, 2'd0, 4'd0, 102 ^ 100);
    endtask

    task automatic t_indirect;
        push(4'd10, 32'h2004, 2'd2, 16'd104);
        expect_none("R3");
        push(4'd0, 32'h3000, 2'd1, 16'd105);
        expect_msg("R5", 6'd4, 4, 32'h1000, 2'd0, 4'd0, 104 ^ 102);
        push(4'd10, 32'h3002, 2'd2, 16'd106);
        expect_none("R3");
        push(4'd0, 32'h3100, 2'd2, 16'd107);
        expect_msg("R6", 6'd4, 3, 32'h0080, 2'd0, 4'd0, 106 ^ 104);
    endtask

    task automatic t_full;
        for (int i = 0; i < 7; i++) begin
            push(4'd0, 32'h3104 + 4*i, 2'd2, 16'(108 + i));
            expect_none("R7");
        end
        push(4'd0, 32'h3200, 2'd2, 16'd115);
        expect_msg("R7", 6'd27, 16, 0, 2'd0, 4'd0, 0);
        push(4'd0, 32'h3204, 2'd2, 16'd116);
        expect_none("R7");
    endtask

    task automatic t_disable;
        @(negedge clk);
        trace_en = 1'b0;
        push(4'd0, 32'h3208, 2'd2, 16'd117);
        expect_msg("R8", 6'd33, 2, 0, 2'd0, 4'd4, 116 ^ 106);
        push(4'd5, 32'h320c, 2'd2, 16'd118);
        expect_none("R8");
        push(4'd0, 32'h3210, 2'd2, 16'd119);
        expect_none("R8");
    endtask

    task automatic t_reenable;
        @(negedge clk);
        trace_en = 1'b1;
        idle_cycles(1);
        push(4'd0, 32'h4000, 2'd2, 16'd200);
        expect_msg("R9", 6'd9, 0, 32'h2000, 2'd0, 4'd5, 200);
    endtask

    task automatic t_full_then_rise;
        for (int i = 0; i < 7; i++) begin
            push(4'd0, 32'h4004 + 4*i, 2'd2, 16'(201 + i));
            expect_none("R7");
        end
        @(negedge clk);
        trace_en = 1'b0;
        idle_cycles(2);
        push(4'd0, 32'h4100, 2'd2, 16'd220);
        expect_none("R8");
        @(negedge clk);
        trace_en = 1'b1;
        idle_cycles(1);
        push(4'd0, 32'h5000, 2'd2, 16'd300);
        expect_msg("R9", 6'd9, 0, 32'h2800, 2'd0, 4'd5, 300);
    endtask

    task automatic t_stall;
        push(4'd5, 32'h5004, 2'd2, 16'd301);
        expect_none("R3");
        @(negedge clk);
        msg_ready = 1'b0;
        push(4'd0, 32'h6000, 2'd2, 16'd302);
        expect_msg("R4", 6'd3, 4, 0, 2'd0, 4'd0, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10", "rec_ready while stalled", rec_ready, 0);
            check("R10", "code held", msg_code, 6'd3);
            check("R10", "valid held", msg_valid, 1);
        end
        msg_ready = 1'b1;
        @(posedge clk);
        #1;
        check("R10", "message released", msg_valid, 0);
        check("R10", "rec_ready restored", rec_ready, 1);
    endtask

    initial begin
        t_reset();
        t_sync();
        t_direct();
        t_indirect();
        t_full();
        t_disable();
        t_reenable();
        t_full_then_rise();
        t_stall();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule